// File: doc/BRIEF.md
# Command/Response Queue Register Front End

This block is the software-facing register port of a serial-bus host controller. Software writes command words into a command queue and reads completed results out of a response queue, all through a 12-bit address, 32-bit data register port. The controller engine behind the block drains commands over a valid/ready stream and returns 16-bit responses over a second valid/ready stream. The engine itself and the bit-clock counter are outside this block.

Besides the two queues, the register port carries read-only capability words (divider width, both queue depths, and whether the divider may be written), a clock-divider setting that is handed to the counter, and a command-threshold setting. Two event outputs feed the interrupt logic. The first is a one-cycle pulse for every response the engine hands over. The second is a level that stays high while the command queue holds no more entries than the threshold.

A register read is combinational. `busRdata` is valid in the same cycle as `busRead`, and any side effect of that read (a response pop) takes place at the closing clock edge. A write takes effect at the clock edge in which `busWrite` is high. All addresses below are byte offsets on `busAddr`.

Top module: `cmd_rsp_front`

## Requirements
- R1: After reset both queues are empty: `cmdValid`=0, `rspReady`=1, `rspPushPulse`=0, the threshold reads 0, `cmdLowLevel`=1, and `divValue` equals the DIV_INIT parameter (0 leaves the divider disabled).
- R2: A write at 0x018 appends the full 32-bit word to the command queue. `cmdValid` is high whenever the queue is non-empty, and `cmdData` shows the oldest entry. An entry leaves the queue at a clock edge where `cmdValid` and `cmdReady` are both high, so entries leave in the order they were written.
- R3: A write at 0x018 while the command queue holds CMD_DEPTH entries is dropped, even if the engine drains an entry in the same cycle. The queue contents and their order stay unchanged.
- R4: A read at 0x014 on a non-empty response queue returns the oldest response in bits 15:0, 1 in bit 31 and 0 elsewhere, and pops that entry. On an empty queue the read returns 0 and changes nothing.
- R5: A read at 0x018 returns the free command slots (CMD_DEPTH minus occupancy) in bits 31:16 and the response-queue occupancy in bits 15:0.
- R6: Capability reads return DIV_WIDTH in bits 7:0 at 0x008, CMD_DEPTH in bits 15:8 and RSP_DEPTH in bits 7:0 at 0x00C, and the DIV_WRITABLE flag in bit 1 at 0x010, with all other bits 0. Writes to these offsets have no effect.
- R7: The divider word at 0x01C reads back `divValue` zero-extended. When DIV_WRITABLE=1, a write loads the low DIV_WIDTH bits. When DIV_WRITABLE=0, writes are ignored and the value stays at DIV_INIT.
- R8: The threshold at 0x020 is a 32-bit read/write word. `cmdLowLevel` is high in every cycle where command-queue occupancy is less than or equal to the threshold (unsigned), and low otherwise.
- R9: `rspReady` is high exactly when the response queue is not full. A response is accepted at an edge where `rspValid` and `rspReady` are both high. `rspPushPulse` is high for exactly the one cycle after each accepted response.
- R10: Reads of any other offset return 0, and writes to any other offset have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 12 | Register byte offset |
| busRead | input | 1 | Read strobe, one cycle per access |
| busWrite | input | 1 | Write strobe, one cycle per access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid while busRead is high |
| cmdValid | output | 1 | Command queue has an entry for the engine |
| cmdReady | input | 1 | Engine takes the head command |
| cmdData | output | 32 | Oldest queued command |
| rspValid | input | 1 | Engine offers a response |
| rspReady | output | 1 | Response queue has room |
| rspData | input | 16 | Response payload |
| rspPushPulse | output | 1 | One-cycle event per accepted response |
| cmdLowLevel | output | 1 | Command occupancy is at or below the threshold |
| divValue | output | DIV_WIDTH | Clock-divider setting for the counter |

## Verification
The main instance is built with a command depth of 4, a response depth of 3, a 12-bit divider, DIV_INIT=5 and a writable divider. The small queues let random traffic reach the full and empty states over and over. The depth of 3 makes the read and write pointers wrap at a count that is not a power of two. The 12-bit width shows that divider writes are masked. A second instance uses the default depths with DIV_WRITABLE=0 and DIV_INIT=9, so both capability encodings and the read-only divider are covered.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

  localparam logic [11:0] OFS_CAP_DIV   = 12'h008;
  localparam logic [11:0] OFS_CAP_DEPTH = 12'h00C;
  localparam logic [11:0] OFS_CAP_FLAGS = 12'h010;
  localparam logic [11:0] OFS_RSP       = 12'h014;
  localparam logic [11:0] OFS_CMD       = 12'h018;
  localparam logic [11:0] OFS_DIV       = 12'h01C;
  localparam logic [11:0] OFS_THR       = 12'h020;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CAP_DIV,
    SEL_CAP_DEPTH,
    SEL_CAP_FLAGS,
    SEL_RSP,
    SEL_STATUS,
    SEL_DIV,
    SEL_THR
  } readSel_e;

  typedef struct packed {
    logic     cmdPush;
    logic     rspPop;
    logic     divWrite;
    logic     thrWrite;
    readSel_e readSel;
  } strobes_t;

endpackage

// File: rtl/cmdq_fifo.sv
module cmdq_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic             doPush;
  logic             doPop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full     = (count == CNT_W'(DEPTH));
  assign empty    = (count == '0);
  assign doPush   = push && !full;
  assign doPop    = pop && !empty;
  assign headData = store[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= bump(wrPtr);
      if (doPop)  rdPtr <= bump(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) store[wrPtr] <= pushData;
  end

endmodule

// File: rtl/cmdq_ctrl.sv
module cmdq_ctrl
  import cmdq_pkg::*;
#(
  parameter bit DIV_WRITABLE = 1'b1
) (
  input  logic        busRead,
  input  logic        busWrite,
  input  logic [11:0] busAddr,
  input  logic        cmdFull,
  input  logic        rspEmpty,
  output strobes_t    strb
);

  always_comb begin
    strb.cmdPush  = 1'b0;
    strb.rspPop   = 1'b0;
    strb.divWrite = 1'b0;
    strb.thrWrite = 1'b0;
    strb.readSel  = SEL_NONE;

    if (busWrite) begin
      case (busAddr)
        OFS_CMD: strb.cmdPush  = !cmdFull;
        OFS_DIV: strb.divWrite = DIV_WRITABLE;
        OFS_THR: strb.thrWrite = 1'b1;
        default: ;
      endcase
    end

    if (busRead) begin
      case (busAddr)
        OFS_CAP_DIV:   strb.readSel = SEL_CAP_DIV;
        OFS_CAP_DEPTH: strb.readSel = SEL_CAP_DEPTH;
        OFS_CAP_FLAGS: strb.readSel = SEL_CAP_FLAGS;
        OFS_RSP: begin
          strb.readSel = SEL_RSP;
          strb.rspPop  = !rspEmpty;
        end
        OFS_CMD:       strb.readSel = SEL_STATUS;
        OFS_DIV:       strb.readSel = SEL_DIV;
        OFS_THR:       strb.readSel = SEL_THR;
        default:       strb.readSel = SEL_NONE;
      endcase
    end
  end

endmodule

// File: rtl/cmdq_datapath.sv
module cmdq_datapath
  import cmdq_pkg::*;
#(
  parameter int CMD_DEPTH    = 8,
  parameter int RSP_DEPTH    = 8,
  parameter int DIV_WIDTH    = 16,
  parameter int DIV_INIT     = 0,
  parameter bit DIV_WRITABLE = 1'b1,
  localparam int CMD_W  = 32,
  localparam int RSP_W  = 16,
  localparam int CCNT_W = $clog2(CMD_DEPTH + 1),
  localparam int RCNT_W = $clog2(RSP_DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobes_t             strb,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  output logic                 cmdValid,
  input  logic                 cmdReady,
  output logic [CMD_W-1:0]     cmdData,
  input  logic                 rspValid,
  output logic                 rspReady,
  input  logic [RSP_W-1:0]     rspData,
  output logic                 rspPushPulse,
  output logic                 cmdLowLevel,
  output logic [DIV_WIDTH-1:0] divValue,
  output logic                 cmdFull,
  output logic                 rspEmpty
);

  logic [CCNT_W-1:0]    cmdCount;
  logic                 cmdEmpty;
  logic [RCNT_W-1:0]    rspCount;
  logic                 rspFull;
  logic [RSP_W-1:0]     rspHead;
  logic                 rspAccept;
  logic [31:0]          thrReg;
  logic [DIV_WIDTH-1:0] divReg;

  cmdq_fifo #(.WIDTH(CMD_W), .DEPTH(CMD_DEPTH)) u_cmdFifo (
    .clk      (clk),
    .rstN     (rstN),
    .push     (strb.cmdPush),
    .pushData (busWdata),
    .pop      (cmdReady),
    .headData (cmdData),
    .count    (cmdCount),
    .full     (cmdFull),
    .empty    (cmdEmpty)
  );

  assign rspAccept = rspValid && !rspFull;

  cmdq_fifo #(.WIDTH(RSP_W), .DEPTH(RSP_DEPTH)) u_rspFifo (
    .clk      (clk),
    .rstN     (rstN),
    .push     (rspAccept),
    .pushData (rspData),
    .pop      (strb.rspPop),
    .headData (rspHead),
    .count    (rspCount),
    .full     (rspFull),
    .empty    (rspEmpty)
  );

  assign cmdValid    = !cmdEmpty;
  assign rspReady    = !rspFull;
  assign divValue    = divReg;
  assign cmdLowLevel = (32'(cmdCount) <= thrReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      thrReg       <= '0;
      divReg       <= DIV_WIDTH'(DIV_INIT);
      rspPushPulse <= 1'b0;
    end else begin
      rspPushPulse <= rspAccept;
      if (strb.thrWrite) thrReg <= busWdata;
      if (strb.divWrite) divReg <= busWdata[DIV_WIDTH-1:0];
    end
  end

  always_comb begin
    case (strb.readSel)
      SEL_CAP_DIV:   busRdata = {24'b0, 8'(DIV_WIDTH)};
      SEL_CAP_DEPTH: busRdata = {16'b0, 8'(CMD_DEPTH), 8'(RSP_DEPTH)};
      SEL_CAP_FLAGS: busRdata = {30'b0, DIV_WRITABLE, 1'b0};
      SEL_RSP:       busRdata = rspEmpty ? 32'b0 : {1'b1, 15'b0, rspHead};
      SEL_STATUS:    busRdata = {16'(CMD_DEPTH) - 16'(cmdCount), 16'(rspCount)};
      SEL_DIV:       busRdata = 32'(divReg);
      SEL_THR:       busRdata = thrReg;
      default:       busRdata = 32'b0;
    endcase
  end

endmodule

// File: rtl/cmd_rsp_front.sv
module cmd_rsp_front
  import cmdq_pkg::*;
#(
  parameter int CMD_DEPTH    = 8,
  parameter int RSP_DEPTH    = 8,
  parameter int DIV_WIDTH    = 16,
  parameter int DIV_INIT     = 0,
  parameter bit DIV_WRITABLE = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [11:0]          busAddr,
  input  logic                 busRead,
  input  logic                 busWrite,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  output logic                 cmdValid,
  input  logic                 cmdReady,
  output logic [31:0]          cmdData,
  input  logic                 rspValid,
  output logic                 rspReady,
  input  logic [15:0]          rspData,
  output logic                 rspPushPulse,
  output logic                 cmdLowLevel,
  output logic [DIV_WIDTH-1:0] divValue
);

  strobes_t strb;
  logic     cmdFull;
  logic     rspEmpty;

  cmdq_ctrl #(.DIV_WRITABLE(DIV_WRITABLE)) u_ctrl (
    .busRead  (busRead),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .cmdFull  (cmdFull),
    .rspEmpty (rspEmpty),
    .strb     (strb)
  );

  cmdq_datapath #(
    .CMD_DEPTH    (CMD_DEPTH),
    .RSP_DEPTH    (RSP_DEPTH),
    .DIV_WIDTH    (DIV_WIDTH),
    .DIV_INIT     (DIV_INIT),
    .DIV_WRITABLE (DIV_WRITABLE)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .busWdata     (busWdata),
    .busRdata     (busRdata),
    .cmdValid     (cmdValid),
    .cmdReady     (cmdReady),
    .cmdData      (cmdData),
    .rspValid     (rspValid),
    .rspReady     (rspReady),
    .rspData      (rspData),
    .rspPushPulse (rspPushPulse),
    .cmdLowLevel  (cmdLowLevel),
    .divValue     (divValue),
    .cmdFull      (cmdFull),
    .rspEmpty     (rspEmpty)
  );

endmodule

// File: rtl/cmd_rsp_front_chk.sv
module cmd_rsp_front_chk #(
  parameter int CMD_DEPTH    = 8,
  parameter int RSP_DEPTH    = 8,
  parameter int DIV_WIDTH    = 16,
  parameter bit DIV_WRITABLE = 1'b1
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [11:0]          busAddr,
  input logic                 busRead,
  input logic [31:0]          busRdata,
  input logic                 cmdValid,
  input logic                 cmdReady,
  input logic [31:0]          cmdData,
  input logic                 rspValid,
  input logic                 rspReady,
  input logic                 rspPushPulse,
  input logic                 cmdLowLevel,
  input logic [DIV_WIDTH-1:0] divValue
);

  // R2: a stalled head entry stays presented and unchanged
  assert_cmd_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdReady) |=> (cmdValid && $stable(cmdData)));

  // R3, R5: the status word never reports more than the queue sizes
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busRead && busAddr == 12'h018) |->
      (busRdata[31:16] <= 16'(CMD_DEPTH) && busRdata[15:0] <= 16'(RSP_DEPTH)));

  // R4: a response read without the valid flag is all zeros
  assert_empty_read_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busRead && busAddr == 12'h014 && !busRdata[31]) |-> (busRdata == 32'b0));

  // R8: an empty command queue is at or below any threshold
  assert_low_when_empty_R8: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |-> cmdLowLevel);

  // R9: a push event only follows an offered and accepted response
  assert_pulse_source_R9: assert property (@(posedge clk) disable iff (!rstN)
    rspPushPulse |-> $past(rspValid && rspReady));

  generate
    if (!DIV_WRITABLE) begin : g_fixedDiv
      // R7: a read-only divider never moves
      assert_div_fixed_R7: assert property (@(posedge clk) disable iff (!rstN)
        1'b1 |=> $stable(divValue));
    end
  endgenerate

endmodule

bind cmd_rsp_front cmd_rsp_front_chk #(
  .CMD_DEPTH    (CMD_DEPTH),
  .RSP_DEPTH    (RSP_DEPTH),
  .DIV_WIDTH    (DIV_WIDTH),
  .DIV_WRITABLE (DIV_WRITABLE)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .busAddr      (busAddr),
  .busRead      (busRead),
  .busRdata     (busRdata),
  .cmdValid     (cmdValid),
  .cmdReady     (cmdReady),
  .cmdData      (cmdData),
  .rspValid     (rspValid),
  .rspReady     (rspReady),
  .rspPushPulse (rspPushPulse),
  .cmdLowLevel  (cmdLowLevel),
  .divValue     (divValue)
);

// File: tb/cmd_rsp_front_tb.sv
`timescale 1ns/1ps
module cmd_rsp_front_tb;

  localparam int CD = 4;
  localparam int RD = 3;
  localparam int DW = 12;
  localparam int DI = 5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busRead = 1'b0;
  logic        busWrite = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        cmdValid;
  logic        cmdReady = 1'b0;
  logic [31:0] cmdData;
  logic        rspValid = 1'b0;
  logic        rspReady;
  logic [15:0] rspData = '0;
  logic        rspPushPulse;
  logic        cmdLowLevel;
  logic [DW-1:0] divValue;

  logic [11:0] fAddr = '0;
  logic        fRead = 1'b0;
  logic        fWrite = 1'b0;
  logic [31:0] fWdata = '0;
  logic [31:0] fRdata;
  logic        fCmdValid, fRspReady, fPulse, fLow;
  logic [31:0] fCmdData;
  logic [15:0] fDiv;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [31:0] cq[$];
  logic [15:0] rq[$];
  logic [31:0] thrM;
  logic [31:0] divM;
  logic        pulseM;

  always #10 clk = ~clk;

  cmd_rsp_front #(.CMD_DEPTH(CD), .RSP_DEPTH(RD), .DIV_WIDTH(DW), .DIV_INIT(DI),
                  .DIV_WRITABLE(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRead(busRead), .busWrite(busWrite),
    .busWdata(busWdata), .busRdata(busRdata), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdData(cmdData), .rspValid(rspValid), .rspReady(rspReady), .rspData(rspData),
    .rspPushPulse(rspPushPulse), .cmdLowLevel(cmdLowLevel), .divValue(divValue));

  cmd_rsp_front #(.DIV_INIT(9), .DIV_WRITABLE(1'b0)) u_dutFixed (
    .clk(clk), .rstN(rstN), .busAddr(fAddr), .busRead(fRead), .busWrite(fWrite),
    .busWdata(fWdata), .busRdata(fRdata), .cmdValid(fCmdValid), .cmdReady(1'b0),
    .cmdData(fCmdData), .rspValid(1'b0), .rspReady(fRspReady), .rspData(16'h0),
    .rspPushPulse(fPulse), .cmdLowLevel(fLow), .divValue(fDiv));

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expRead(input logic [11:0] a);
    case (a)
      12'h008: return 32'(DW);
      12'h00C: return (32'(CD) << 8) | 32'(RD);
      12'h010: return 32'h2;
      12'h014: return (rq.size() > 0) ? {1'b1, 15'b0, rq[0]} : 32'b0;
      12'h018: return {16'(CD - cq.size()), 16'(rq.size())};
      12'h01C: return divM;
      12'h020: return thrM;
      default: return 32'b0;
    endcase
  endfunction

  function automatic string tagFor(input logic [11:0] a);
    case (a)
      12'h008, 12'h00C, 12'h010: return "R6 capability read";
      12'h014: return "R4 response read";
      12'h018: return "R5 status read";
      12'h01C: return "R7 divider read";
      12'h020: return "R8 threshold read";
      default: return "R10 unmapped read";
    endcase
  endfunction

  // One bus cycle: inputs applied at the falling edge, outputs compared
  // against the model, model advanced as the rising edge will.
  task automatic step(input bit rd, input bit wr, input logic [11:0] a,
                      input logic [31:0] wd, input bit crdy, input bit rv,
                      input logic [15:0] rdat);
    bit cPop, cPush, rPop, rPush;
    busRead = rd; busWrite = wr; busAddr = a; busWdata = wd;
    cmdReady = crdy; rspValid = rv; rspData = rdat;
    #1;
    check(cmdValid == (cq.size() > 0), "R2 cmdValid", 32'(cmdValid), 32'(cq.size() > 0));
    if (cq.size() > 0) check(cmdData == cq[0], "R2 cmdData order", cmdData, cq[0]);
    check(rspReady == (rq.size() < RD), "R9 rspReady", 32'(rspReady), 32'(rq.size() < RD));
    check(cmdLowLevel == (32'(cq.size()) <= thrM), "R8 cmdLowLevel",
          32'(cmdLowLevel), 32'(32'(cq.size()) <= thrM));
    check(rspPushPulse == pulseM, "R9 rspPushPulse", 32'(rspPushPulse), 32'(pulseM));
    check(32'(divValue) == divM, "R7 divValue", 32'(divValue), divM);
    if (rd) check(busRdata == expRead(a), tagFor(a), busRdata, expRead(a));
    cPop  = (cq.size() > 0) && crdy;
    cPush = wr && a == 12'h018 && cq.size() < CD;
    rPop  = rd && a == 12'h014 && rq.size() > 0;
    rPush = rv && rq.size() < RD;
    if (cPop) void'(cq.pop_front());
    if (cPush) cq.push_back(wd);
    if (rPop) void'(rq.pop_front());
    if (rPush) rq.push_back(rdat);
    if (wr && a == 12'h01C) divM = wd & ((32'd1 << DW) - 1);
    if (wr && a == 12'h020) thrM = wd;
    pulseM = rPush;
    @(negedge clk);
  endtask

  task automatic idle(); step(0, 0, 12'h0, 0, 0, 0, 0); endtask
  task automatic rd(input logic [11:0] a); step(1, 0, a, 0, 0, 0, 0); endtask
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    step(0, 1, a, d, 0, 0, 0);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  function automatic logic [11:0] pickAddr();
    case ($urandom % 11)
      0: return 12'h008; 1: return 12'h00C; 2: return 12'h010;
      3, 4: return 12'h014; 5, 6: return 12'h018;
      7: return 12'h01C; 8: return 12'h020;
      9: return 12'h024; default: return 12'hFFC;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    thrM = 0; divM = DI; pulseM = 0;
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    check(cmdValid == 1'b0, "R1 reset cmdValid", 32'(cmdValid), 0);
    check(rspReady == 1'b1, "R1 reset rspReady", 32'(rspReady), 1);
    check(rspPushPulse == 1'b0, "R1 reset pulse", 32'(rspPushPulse), 0);
    check(cmdLowLevel == 1'b1, "R1 reset cmdLowLevel", 32'(cmdLowLevel), 1);
    check(32'(divValue) == DI, "R1 reset divValue", 32'(divValue), DI);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    rd(12'h020); rd(12'h01C);

    // R6: capability words, writes ignored
    rd(12'h008); rd(12'h00C); rd(12'h010);
    wr(12'h008, 32'hFFFF_FFFF); wr(12'h00C, 32'h1234_5678); wr(12'h010, 32'h0);
    rd(12'h008); rd(12'h00C); rd(12'h010);

    // R4: empty response read returns 0, R5 status
    rd(12'h014); rd(12'h018);

    // R2, R3: fill commands, then overflow with and without a drain
    for (int i = 0; i < CD; i++) wr(12'h018, 32'hC0DE_0000 + i);
    rd(12'h018);
    wr(12'h018, 32'hDEAD_BEEF);
    step(0, 1, 12'h018, 32'hBAD0_0001, 1, 0, 0);
    rd(12'h018);
    for (int i = 0; i < CD; i++) step(0, 0, 12'h0, 0, 1, 0, 0);
    idle();

    // R9, R4: fill responses, one extra offer refused, drain with reads
    for (int i = 0; i < RD + 1; i++) step(0, 0, 12'h0, 0, 0, 1, 16'hA500 + 16'(i));
    rd(12'h018);
    for (int i = 0; i < RD + 1; i++) rd(12'h014);
    // R4: simultaneous pop and accept when full
    for (int i = 0; i < RD; i++) step(0, 0, 12'h0, 0, 0, 1, 16'h5A00 + 16'(i));
    step(1, 0, 12'h014, 0, 0, 1, 16'h7777);
    step(1, 0, 12'h014, 0, 0, 1, 16'h8888);
    for (int i = 0; i < RD + 1; i++) rd(12'h014);

    // R8: threshold level
    wr(12'h020, 32'd2);
    for (int i = 0; i < CD; i++) wr(12'h018, 32'h0000_1000 + i);
    rd(12'h020);
    for (int i = 0; i < CD; i++) step(0, 0, 12'h0, 0, 1, 0, 0);
    wr(12'h020, 32'hFFFF_FFFF); idle();

    // R7: masked divider write
    wr(12'h01C, 32'h000A_BCDE); rd(12'h01C);
    // R10: unmapped offsets
    wr(12'h024, 32'hFFFF_FFFF); wr(12'hFFC, 32'h1); rd(12'h024); rd(12'hFFC); rd(12'h020);

    // Random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [11:0] a = pickAddr();
      bit doRd = ($urandom % 2) == 1;
      bit doWr = !doRd && ($urandom % 3) != 0;
      logic [31:0] d = $urandom;
      if (a == 12'h020) d = $urandom % 6;
      step(doRd, doWr, a, d, ($urandom % 3) == 0, ($urandom % 2) == 1, 16'($urandom));
    end

    // R7, R6: read-only divider instance
    fAddr = 12'h01C; fWdata = 32'h0000_1234; fWrite = 1'b1;
    @(negedge clk);
    fWrite = 1'b0; fRead = 1'b1;
    #1;
    check(fRdata == 32'd9, "R7 fixed divider read", fRdata, 9);
    check(fDiv == 16'd9, "R7 fixed divValue", 32'(fDiv), 9);
    fAddr = 12'h010; #1;
    check(fRdata == 32'h0, "R6 fixed flag word", fRdata, 0);
    fAddr = 12'h00C; #1;
    check(fRdata == 32'h0808, "R6 default depths", fRdata, 32'h0808);
    fAddr = 12'h008; #1;
    check(fRdata == 32'd16, "R6 default width", fRdata, 16);
    fRead = 1'b0;
    @(negedge clk);
    finishRun();
  end

endmodule